// File: doc/BRIEF.md
# Custom Instruction Execute Unit

This unit sits next to a 32-bit RISC-V integer pipeline and executes user-defined instructions drawn from the four opcodes set aside for custom extensions. The host pipeline presents the instruction word, up to four 32-bit operands it has already read from its register file, and a one-cycle start strobe. The unit works out the instruction layout from the opcode and picks the operation. It then returns a 32-bit result with a one-cycle done pulse, or a one-cycle illegal pulse when the operation is refused or runs too long.

Three of the four built-in operations finish in the start cycle and are registered at the start edge. A multiply-add is pipelined over three cycles. An operation that never reports completion is cut off by a bounded cycle window. Operations use that same path to report a request they cannot serve. The unit also reports where the third and fourth source register indices sit in the word, so the host can read those extra operands.

Top module: `custom_op_unit`

## Requirements
- R1: Only opcodes (instr[6:0]) 0001011 (three-operand form), 0101011 (four-operand form), 1011011 (five-register form A) and 1111011 (five-register form B) are accepted; a start with any other opcode produces neither done nor illegal.
- R2: In the three-operand form the 10-bit selector {instr[31:25], instr[14:12]} equal to zero computes ~(opA ^ opB); done is high in the cycle after the start edge.
- R3: In the four-operand form, instr[14:12] equal to zero computes the low 32 bits of opA*opB + opC; done is high three cycles after the start edge, and instr[26:25] have no effect on the result.
- R4: Five-register form A returns opA & opB & opC & opD and form B returns opA ^ opB ^ opC ^ opD, both with done in the cycle after the start edge, whatever bits 31:7 hold.
- R5: No field other than the opcode is ever checked: register index bits, including their upper bits, never cause an illegal pulse.
- R6: With ENABLE = 0, a start carrying any of the four opcodes gives an illegal pulse in the cycle after the start edge, result zero and no done.
- R7: A three-operand selector other than zero, or a four-operand instr[14:12] other than zero, never completes; illegal pulses exactly TIMEOUT cycles after the start edge, with result zero.
- R8: done and illegal are never high together, and resultOut is zero in every cycle without done; combinational operations may complete in back-to-back cycles.
- R9: A start that arrives while a multi-cycle operation is in flight is ignored and does not alter that operation's result.
- R10: rs3IdxOut equals instr[31:27] for the four-operand and both five-register forms and is zero otherwise; rs4IdxOut equals {instr[26:25], instr[14:12]} for the five-register forms and is zero otherwise.
- R11: While reset is asserted and after it is released with no start, doneOut, illegalOut and resultOut are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | One-cycle strobe launching the instruction on instrIn |
| instrIn | input | 32 | Instruction word |
| opA | input | DATA_W | First source operand |
| opB | input | DATA_W | Second source operand |
| opC | input | DATA_W | Third source operand |
| opD | input | DATA_W | Fourth source operand |
| rs3IdxOut | output | 5 | Third source register index decoded from instrIn |
| rs4IdxOut | output | 5 | Fourth source register index decoded from instrIn |
| resultOut | output | DATA_W | Result, valid with doneOut, zero otherwise |
| doneOut | output | 1 | One-cycle completion pulse |
| illegalOut | output | 1 | One-cycle illegal-instruction pulse |

## Verification
On every cycle the assertions check that done and illegal are exclusive, that the result is zero outside done, and that a foreign opcode never yields an output. A cycle counter in the checker pins every done to latency one or three and every illegal to the timeout window, or to one cycle when the unit is disabled. Only the bench scenarios can show the arithmetic values, that ignored instruction bits leave the result unchanged, that a start during a multiply-add is dropped, and the decoded register index positions.

// File: rtl/custom_op_pkg.sv
package custom_op_pkg;

  localparam int INSTR_W    = 32;
  localparam int MAC_STAGES = 3;

  localparam logic [6:0] OPC_R3  = 7'b0001011;
  localparam logic [6:0] OPC_R4  = 7'b0101011;
  localparam logic [6:0] OPC_R5A = 7'b1011011;
  localparam logic [6:0] OPC_R5B = 7'b1111011;

  // Operation chosen for an instruction word
  typedef enum logic [2:0] {
    K_NONE,   // not a custom opcode
    K_XNOR,
    K_MAC,
    K_AND4,
    K_XOR4,
    K_HANG    // custom opcode with no assigned operation
  } opKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    capture;
    logic    finish;
    logic    abort;
    opKind_e kind;
  } ctrlStrobe_t;

  function automatic opKind_e decodeKind(input logic [INSTR_W-1:0] w);
    opKind_e k;
    unique case (w[6:0])
      OPC_R3:  k = ({w[31:25], w[14:12]} == 10'd0) ? K_XNOR : K_HANG;
      OPC_R4:  k = (w[14:12] == 3'd0) ? K_MAC : K_HANG;
      OPC_R5A: k = K_AND4;
      OPC_R5B: k = K_XOR4;
      default: k = K_NONE;
    endcase
    return k;
  endfunction

  function automatic logic isSingleCycle(input opKind_e k);
    return (k == K_XNOR) || (k == K_AND4) || (k == K_XOR4);
  endfunction

endpackage

// File: rtl/custom_op_ctrl.sv
module custom_op_ctrl
  import custom_op_pkg::*;
#(
  parameter int TIMEOUT = 128,
  parameter bit ENABLE  = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  input  logic [INSTR_W-1:0] instrIn,
  output ctrlStrobe_t        strobe,
  output logic               busyOut
);

  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] MAC_LAST = CNT_W'(MAC_STAGES - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT - 1);

  opKind_e          kindLive;
  opKind_e          kindQ;
  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             accept;
  logic             goBusy;

  assign kindLive = decodeKind(instrIn);
  assign accept   = startIn && !busyQ && (kindLive != K_NONE);
  assign goBusy   = accept && ENABLE && !isSingleCycle(kindLive);
  assign busyOut  = busyQ;

  always_comb begin
    strobe      = '0;
    strobe.kind = busyQ ? kindQ : kindLive;
    if (accept) begin
      strobe.capture = 1'b1;
      if (!ENABLE)                          strobe.abort  = 1'b1;
      else if (isSingleCycle(kindLive))     strobe.finish = 1'b1;
    end else if (busyQ) begin
      if (kindQ == K_MAC && cntQ == MAC_LAST) strobe.finish = 1'b1;
      else if (cntQ == TMO_LAST)              strobe.abort  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      kindQ <= K_NONE;
      cntQ  <= '0;
    end else if (goBusy) begin
      busyQ <= 1'b1;
      kindQ <= kindLive;
      cntQ  <= CNT_W'(1);
    end else if (busyQ) begin
      if (strobe.finish || strobe.abort) begin
        busyQ <= 1'b0;
        cntQ  <= '0;
      end else begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/custom_op_dpath.sv
module custom_op_dpath
  import custom_op_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  input  logic [DATA_W-1:0] opD,
  output logic [DATA_W-1:0] resultOut,
  output logic              doneOut,
  output logic              illegalOut
);

  logic [DATA_W-1:0] prodQ;
  logic [DATA_W-1:0] addendQ;
  logic [DATA_W-1:0] sumQ;
  logic [DATA_W-1:0] quickRes;
  logic [DATA_W-1:0] finalRes;
  logic [DATA_W-1:0] resultQ;
  logic              doneQ;
  logic              illegalQ;

  always_comb begin
    unique case (strobe.kind)
      K_XNOR:  quickRes = ~(opA ^ opB);
      K_AND4:  quickRes = opA & opB & opC & opD;
      K_XOR4:  quickRes = opA ^ opB ^ opC ^ opD;
      default: quickRes = '0;
    endcase
  end

  assign finalRes = (strobe.kind == K_MAC) ? sumQ : quickRes;

  // Multiply-add pipeline: product and addend at start, sum one cycle later
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodQ   <= '0;
      addendQ <= '0;
      sumQ    <= '0;
    end else begin
      if (strobe.capture) begin
        prodQ   <= opA * opB;
        addendQ <= opC;
      end
      sumQ <= prodQ + addendQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ  <= '0;
      doneQ    <= 1'b0;
      illegalQ <= 1'b0;
    end else begin
      doneQ    <= strobe.finish;
      illegalQ <= strobe.abort;
      resultQ  <= strobe.finish ? finalRes : '0;
    end
  end

  assign resultOut  = resultQ;
  assign doneOut    = doneQ;
  assign illegalOut = illegalQ;

endmodule

// File: rtl/custom_op_unit.sv
module custom_op_unit
  import custom_op_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TIMEOUT = 128,
  parameter bit ENABLE  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [31:0]       instrIn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  input  logic [DATA_W-1:0] opD,
  output logic [4:0]        rs3IdxOut,
  output logic [4:0]        rs4IdxOut,
  output logic [DATA_W-1:0] resultOut,
  output logic              doneOut,
  output logic              illegalOut
);

  ctrlStrobe_t strobe;
  logic        busyW;
  logic [6:0]  opc;
  logic        isR4;
  logic        isR5;

  assign opc  = instrIn[6:0];
  assign isR4 = (opc == OPC_R4);
  assign isR5 = (opc == OPC_R5A) || (opc == OPC_R5B);

  assign rs3IdxOut = (isR4 || isR5) ? instrIn[31:27] : 5'd0;
  assign rs4IdxOut = isR5 ? {instrIn[26:25], instrIn[14:12]} : 5'd0;

  custom_op_ctrl #(
    .TIMEOUT(TIMEOUT),
    .ENABLE (ENABLE)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .startIn(startIn),
    .instrIn(instrIn),
    .strobe (strobe),
    .busyOut(busyW)
  );

  custom_op_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .opC       (opC),
    .opD       (opD),
    .resultOut (resultOut),
    .doneOut   (doneOut),
    .illegalOut(illegalOut)
  );

endmodule

// File: rtl/custom_op_unit_chk.sv
module custom_op_unit_chk
  import custom_op_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TIMEOUT = 128,
  parameter bit ENABLE  = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              startIn,
  input logic [6:0]        opcIn,
  input logic              busyW,
  input logic [DATA_W-1:0] resultOut,
  input logic              doneOut,
  input logic              illegalOut
);

  localparam int EXP_ABORT = ENABLE ? TIMEOUT : 1;

  logic        isCustom;
  logic        accepted;
  int unsigned chkCnt;

  assign isCustom = (opcIn == OPC_R3) || (opcIn == OPC_R4) ||
                    (opcIn == OPC_R5A) || (opcIn == OPC_R5B);
  assign accepted = startIn && !busyW && isCustom;

  // Cycles since the last accepted start
  always_ff @(posedge clk) begin
    if (!rstN)                    chkCnt <= 0;
    else if (accepted)            chkCnt <= 1;
    else if (chkCnt != 32'hFFFF)  chkCnt <= chkCnt + 1;
  end

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOut && illegalOut));

  assert_zero_result_R8: assert property (@(posedge clk) disable iff (!rstN)
    !doneOut |-> (resultOut == '0));

  assert_foreign_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busyW && !isCustom) |=> (!doneOut && !illegalOut));

  assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (chkCnt == 1 || chkCnt == MAC_STAGES));

  assert_abort_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    illegalOut |-> (chkCnt == EXP_ABORT));

  generate
    if (!ENABLE) begin : g_off
      assert_no_done_R6: assert property (@(posedge clk) disable iff (!rstN)
        !doneOut);
    end
  endgenerate

endmodule

bind custom_op_unit custom_op_unit_chk #(
  .DATA_W (DATA_W),
  .TIMEOUT(TIMEOUT),
  .ENABLE (ENABLE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startIn   (startIn),
  .opcIn     (instrIn[6:0]),
  .busyW     (busyW),
  .resultOut (resultOut),
  .doneOut   (doneOut),
  .illegalOut(illegalOut)
);

// File: tb/test_custom_op_unit.sv
module test_custom_op_unit;
  import custom_op_pkg::*;

  localparam int TMO = 128;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic        startOff = 1'b0;
  logic [31:0] instrIn = '0;
  logic [31:0] opA = '0, opB = '0, opC = '0, opD = '0;

  logic [4:0]  rs3IdxOut, rs4IdxOut;
  logic [31:0] resultOut;
  logic        doneOut, illegalOut;
  logic [4:0]  offRs3, offRs4;
  logic [31:0] offResult;
  logic        offDone, offIllegal;

  always #4 clk = ~clk;

  custom_op_unit #(.DATA_W(32), .TIMEOUT(TMO), .ENABLE(1'b1)) i_custom_op_unit (
    .clk(clk), .rstN(rstN), .startIn(startIn), .instrIn(instrIn),
    .opA(opA), .opB(opB), .opC(opC), .opD(opD),
    .rs3IdxOut(rs3IdxOut), .rs4IdxOut(rs4IdxOut),
    .resultOut(resultOut), .doneOut(doneOut), .illegalOut(illegalOut));

  custom_op_unit #(.DATA_W(32), .TIMEOUT(TMO), .ENABLE(1'b0)) i_custom_op_unit_off (
    .clk(clk), .rstN(rstN), .startIn(startOff), .instrIn(instrIn),
    .opA(opA), .opB(opB), .opC(opC), .opD(opD),
    .rs3IdxOut(offRs3), .rs4IdxOut(offRs4),
    .resultOut(offResult), .doneOut(offDone), .illegalOut(offIllegal));

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    bit          isIllegal;
    logic [31:0] val;
    int          due;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t monItem;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mac32(input logic [31:0] a, b, c);
    logic [31:0] r;
    r = a * b + c;
    return r;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (doneOut || illegalOut) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R1", "unexpected output", {30'b0, illegalOut, doneOut}, 32'd0);
        end else begin
          monItem = expQ.pop_front();
          check(illegalOut == monItem.isIllegal && doneOut == !monItem.isIllegal,
                monItem.tag, "kind (illegal)", {31'b0, illegalOut}, {31'b0, monItem.isIllegal});
          check(resultOut == monItem.val, monItem.tag, "result", resultOut, monItem.val);
          check(cyc == monItem.due, monItem.tag, "latency", cyc, monItem.due);
        end
      end else if (expQ.size() != 0 && cyc > expQ[0].due) begin
        check(1'b0, expQ[0].tag, "missing output", 32'd0, 32'd1);
        expQ.delete(0);
      end
    end
  end

  task automatic issue(input logic [31:0] w, a, b, c, d,
                       input bit ill, input logic [31:0] val, input int lat, input string tag);
    @(negedge clk);
    instrIn = w; opA = a; opB = b; opC = c; opD = d;
    startIn = 1'b1;
    expQ.push_back('{ill, val, cyc + lat, tag});
    @(negedge clk);
    startIn = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (doneOut || illegalOut) seen = 1'b1;
    end
    check(!seen, tag, "no output expected", {31'b0, seen}, 32'd0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [31:0] w, a, b, c, d;

    // R11: reset state
    repeat (3) @(negedge clk);
    check(doneOut == 1'b0 && illegalOut == 1'b0, "R11", "flags in reset",
          {30'b0, illegalOut, doneOut}, 32'd0);
    check(resultOut == 32'd0, "R11", "result in reset", resultOut, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(doneOut == 1'b0 && illegalOut == 1'b0 && resultOut == 32'd0, "R11",
          "idle after reset", resultOut, 32'd0);

    // R2: xnor, two patterns
    w = {7'd0, 5'd3, 5'd2, 3'd0, 5'd1, OPC_R3};
    a = 32'hF0F0_1234; b = 32'h0FF0_4321;
    issue(w, a, b, 32'h0, 32'h0, 1'b0, ~(a ^ b), 1, "R2");
    a = 32'hFFFF_FFFF; b = 32'h0000_0000;
    issue(w, a, b, 32'h5, 32'h6, 1'b0, ~(a ^ b), 1, "R2");

    // R3: multiply-add, then same with bits 26:25 set and wrapping values
    w = {5'd4, 2'b00, 5'd2, 5'd1, 3'd0, 5'd5, OPC_R4};
    a = 32'h1234_5678; b = 32'h9ABC_DEF0; c = 32'h1111_1111;
    issue(w, a, b, c, 32'h0, 1'b0, mac32(a, b, c), 3, "R3");
    w = {5'd4, 2'b11, 5'd2, 5'd1, 3'd0, 5'd5, OPC_R4};
    a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; c = 32'hFFFF_FFFF;
    issue(w, a, b, c, 32'h0, 1'b0, mac32(a, b, c), 3, "R3");

    // R4: five-register forms with every non-opcode bit set
    a = 32'hFF0F_F0F3; b = 32'hF3FF_0FF1; c = 32'hFFF3_FF0F; d = 32'h7FFF_FFF3;
    issue({25'h1FF_FFFF, OPC_R5A}, a, b, c, d, 1'b0, a & b & c & d, 1, "R4");
    a = 32'h1357_9BDF; b = 32'h2468_ACE0; c = 32'hDEAD_BEEF; d = 32'h0BAD_F00D;
    issue({25'h0A5_5A5A, OPC_R5B}, a, b, c, d, 1'b0, a ^ b ^ c ^ d, 1, "R4");

    // R5: register index upper bits set, still valid
    w = {7'd0, 5'h1F, 5'h1F, 3'd0, 5'h1F, OPC_R3};
    issue(w, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h0, 32'h0, 1'b0, 32'h0000_0000, 1, "R5");

    // R7: unassigned selectors time out
    w = {7'd0, 5'd3, 5'd2, 3'd1, 5'd1, OPC_R3};
    issue(w, 32'h1, 32'h2, 32'h3, 32'h4, 1'b1, 32'h0, TMO, "R7");
    w = {5'd4, 2'b00, 5'd2, 5'd1, 3'd5, 5'd5, OPC_R4};
    issue(w, 32'h1, 32'h2, 32'h3, 32'h4, 1'b1, 32'h0, TMO, "R7");
    w = {7'h40, 5'd3, 5'd2, 3'd0, 5'd1, OPC_R3};
    issue(w, 32'h1, 32'h2, 32'h3, 32'h4, 1'b1, 32'h0, TMO, "R7");

    // R8: back-to-back single-cycle operations
    @(negedge clk);
    a = 32'h0F0F_0F0F; b = 32'hFFFF_0000; c = 32'hFF00_FF00; d = 32'hFFFF_FFFF;
    instrIn = {25'd0, OPC_R5A}; opA = a; opB = b; opC = c; opD = d; startIn = 1'b1;
    expQ.push_back('{1'b0, a & b & c & d, cyc + 1, "R8"});
    @(negedge clk);
    instrIn = {25'd0, OPC_R5B};
    expQ.push_back('{1'b0, a ^ b ^ c ^ d, cyc + 1, "R8"});
    @(negedge clk);
    startIn = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    quiet(3, "R8");

    // R9: start during multiply-add is ignored
    @(negedge clk);
    a = 32'h0000_1234; b = 32'h0000_5678; c = 32'h0000_0042;
    instrIn = {5'd4, 2'b00, 5'd2, 5'd1, 3'd0, 5'd5, OPC_R4};
    opA = a; opB = b; opC = c; startIn = 1'b1;
    expQ.push_back('{1'b0, mac32(a, b, c), cyc + 3, "R9"});
    @(negedge clk);
    instrIn = {25'd0, OPC_R5B}; opA = 32'hDEAD_0000; opB = 32'h1; opC = 32'h2; opD = 32'h3;
    @(negedge clk);
    startIn = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    quiet(6, "R9");

    // R1: foreign opcodes produce nothing
    @(negedge clk);
    instrIn = {7'd0, 5'd3, 5'd2, 3'd0, 5'd1, 7'b0110011}; startIn = 1'b1;
    @(negedge clk);
    instrIn = {25'h1FF_FFFF, 7'b0001111};
    @(negedge clk);
    startIn = 1'b0;
    quiet(8, "R1");

    // R10: register index decode
    @(negedge clk);
    instrIn = {5'd21, 2'b10, 5'd2, 5'd1, 3'b011, 5'd5, OPC_R5A};
    #1;
    check(rs3IdxOut == 5'd21, "R10", "rs3 index form A", {27'b0, rs3IdxOut}, 32'd21);
    check(rs4IdxOut == 5'b10011, "R10", "rs4 index form A", {27'b0, rs4IdxOut}, 32'd19);
    instrIn = {5'd9, 2'b01, 5'd2, 5'd1, 3'b110, 5'd5, OPC_R5B};
    #1;
    check(rs4IdxOut == 5'b01110 && rs3IdxOut == 5'd9, "R10", "indices form B",
          {22'b0, rs3IdxOut, rs4IdxOut}, {22'b0, 5'd9, 5'b01110});
    instrIn = {5'd17, 2'b11, 5'd2, 5'd1, 3'b000, 5'd5, OPC_R4};
    #1;
    check(rs3IdxOut == 5'd17 && rs4IdxOut == 5'd0, "R10", "indices four-operand",
          {22'b0, rs3IdxOut, rs4IdxOut}, {22'b0, 5'd17, 5'd0});
    instrIn = {7'h7F, 5'd31, 5'd31, 3'd7, 5'd31, OPC_R3};
    #1;
    check(rs3IdxOut == 5'd0 && rs4IdxOut == 5'd0, "R10", "indices three-operand",
          {22'b0, rs3IdxOut, rs4IdxOut}, 32'd0);

    // R6: disabled unit flags custom opcodes
    @(negedge clk);
    instrIn = {7'd0, 5'd3, 5'd2, 3'd0, 5'd1, OPC_R3}; opA = 32'h1; opB = 32'h2;
    startOff = 1'b1;
    @(negedge clk);
    startOff = 1'b0;
    check(offIllegal == 1'b1 && offDone == 1'b0, "R6", "disabled flags",
          {30'b0, offIllegal, offDone}, 32'd2);
    check(offResult == 32'd0, "R6", "disabled result", offResult, 32'd0);
    @(negedge clk);
    check(offIllegal == 1'b0, "R6", "illegal is a pulse", {31'b0, offIllegal}, 32'd0);
    instrIn = {25'd0, OPC_R5B}; startOff = 1'b1;
    @(negedge clk);
    startOff = 1'b0;
    check(offIllegal == 1'b1 && offDone == 1'b0, "R6", "disabled form B",
          {30'b0, offIllegal, offDone}, 32'd2);
    @(negedge clk);
    instrIn = {25'd0, 7'b0010011}; startOff = 1'b1;
    @(negedge clk);
    startOff = 1'b0;
    check(offIllegal == 1'b0 && offDone == 1'b0, "R6", "disabled foreign opcode",
          {30'b0, offIllegal, offDone}, 32'd0);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R8", "scoreboard drained", expQ.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule